// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block turns a period word, counted in clock cycles, into two complementary gate-enable signals for a half-bridge: one for the high-side switch and one for the low-side switch. Each switching cycle has two equal halves. The low-side half comes first and the high-side half second. Every half opens with a dead interval in which both enables are low, and the active enable stays high for the rest of that half. The dead interval is fixed at build time. A parameter selects one of two lengths, a slower 1.8 us setting or a faster 1.0 us setting, and the block converts it to clock cycles from the clock frequency.

A mode controller drives a run enable. While the enable is low, both gate enables are held low; this covers undervoltage and fault conditions. Once the enable goes high, the sequence always starts with a low-side pulse, so that the high-side bootstrap supply can charge before the high side ever turns on. A new period word is taken only at the start of a full switching cycle, so a pulse is never cut short.

On every low-side turn-on, the block emits a one-cycle strobe and opens a 400 ns blanking window. During this window the raw zero-crossing comparator input is masked from the qualified output, which keeps switching noise out of the phase measurement.

Top module: `hbs_gate_seq`

## Requirements
- R1: After reset, and while `run_en` is low, `gate_hi`, `gate_lo`, `lo_rise` and `blank_win` are all 0.
- R2: After `run_en` rises, the first gate pulse is on `gate_lo`. Counting the first rising edge that samples `run_en` high as edge 1, `gate_lo` goes high after edge DT+1, and `gate_hi` stays low until that low-side pulse and the following dead interval have finished.
- R3: Each half-cycle lasts H = max(floor(P/2), DT+1) cycles, where P is the latched period word. Within a half, both enables are low for DT cycles and the active enable is then high for H-DT cycles. The order is always low-side half, then high-side half.
- R4: DT = ceil(1800 ns x f_clk) when `FAST_DT`=0, and ceil(1000 ns x f_clk) when `FAST_DT`=1. At 100 MHz these are 180 and 100 cycles.
- R5: `gate_hi` and `gate_lo` are never both high in the same cycle.
- R6: `period_in` is sampled only on the clock edge that starts a low-side dead interval. A change made later in the cycle leaves the current low-side and high-side pulse lengths unchanged.
- R7: When `run_en` is low at a rising edge, both gate enables are low after that edge. The next enable restarts the sequence with a low-side pulse.
- R8: `lo_rise` is high for exactly one cycle: the first cycle in which `gate_lo` is high.
- R9: `blank_win` is high for BLANK cycles (ceil(400 ns x f_clk), 40 at 100 MHz), starting in the `lo_rise` cycle. `zc_qual` equals `zc_raw` when `blank_win` is low and is 0 when `blank_win` is high.
- R10: If floor(P/2) is DT or less, the half-cycle is clamped to DT+1 cycles, so each active pulse is 1 cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable from the mode controller |
| period_in | input | PER_W | Full switching period in clock cycles |
| zc_raw | input | 1 | Raw zero-crossing comparator output |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| lo_rise | output | 1 | One-cycle strobe on low-side turn-on |
| blank_win | output | 1 | Blanking window after low-side turn-on |
| zc_qual | output | 1 | Zero-crossing input with the blanking window applied |

## Verification
A wrong phase register or a slipped phase counter shows up at the gate pins within one half-cycle. It appears as a dead interval or pulse length that differs from DT or H-DT, as a high-side pulse before the first low-side pulse, or as the two enables overlapping. A stale or early-latched period word changes the next measured pulse length, and the bench catches it one switching cycle after the update. A fault in the blanking counter changes where `blank_win` falls relative to `lo_rise`, and `zc_qual` shows it within BLANK cycles of each low-side turn-on.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LO_DEAD = 3'd1,
    PH_LO_ON   = 3'd2,
    PH_HI_DEAD = 3'd3,
    PH_HI_ON   = 3'd4
  } hbs_phase_e;

  // Round a duration in ns up to whole clock cycles.
  function automatic int ns_to_cyc(input longint ns, input longint hz);
    longint prod;
    prod = ns * hz + 64'sd999_999_999;
    return int'(prod / 64'sd1_000_000_000);
  endfunction

endpackage

// File: rtl/hbs_period_latch.sv
module hbs_period_latch #(
  parameter int PER_W  = 16,
  parameter int DT_CYC = 180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PER_W-1:0] period_in,
  output logic [PER_W-1:0] on_len
);

  localparam logic [PER_W-1:0] DT_W = PER_W'(DT_CYC);

  logic [PER_W-1:0] half_raw;
  logic [PER_W-1:0] half_cl;
  logic [PER_W-1:0] on_d;
  logic [PER_W-1:0] on_q;

  // Clamp the half-cycle so that each pulse is at least one cycle long.
  always_comb begin
    half_raw = period_in >> 1;
    half_cl  = (half_raw > DT_W) ? half_raw : (DT_W + 1'b1);
    on_d     = half_cl - DT_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= PER_W'(1);
    end else if (ld) begin
      on_q <= on_d;
    end
  end

  assign on_len = on_q;

  // R10: the latched on-time is never zero
  a_r10_on_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    on_q != '0);

endmodule

// File: rtl/hbs_phase_fsm.sv
module hbs_phase_fsm
  import hbs_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int DT_CYC = 180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PER_W-1:0] on_len,
  output logic             cycle_ld,
  output logic             gate_lo,
  output logic             gate_hi,
  output logic             lo_rise
);

  localparam logic [PER_W-1:0] DT_LAST = PER_W'(DT_CYC - 1);

  hbs_phase_e       phase_q, phase_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             lo_q, hi_q, rise_q;
  logic             dead_done, on_done;

  assign dead_done = (cnt_q == DT_LAST);
  assign on_done   = (cnt_q == on_len - 1'b1);

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q + 1'b1;
    cycle_ld = 1'b0;
    if (!run_en) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LO_DEAD;
          cnt_d    = '0;
          cycle_ld = 1'b1;
        end
        PH_LO_DEAD: if (dead_done) begin
          phase_d = PH_LO_ON;
          cnt_d   = '0;
        end
        PH_LO_ON: if (on_done) begin
          phase_d = PH_HI_DEAD;
          cnt_d   = '0;
        end
        PH_HI_DEAD: if (dead_done) begin
          phase_d = PH_HI_ON;
          cnt_d   = '0;
        end
        PH_HI_ON: if (on_done) begin
          phase_d  = PH_LO_DEAD;
          cnt_d    = '0;
          cycle_ld = 1'b1;
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      lo_q    <= (phase_d == PH_LO_ON);
      hi_q    <= (phase_d == PH_HI_ON);
      rise_q  <= (phase_d == PH_LO_ON) && (phase_q != PH_LO_ON);
    end
  end

  assign gate_lo = lo_q;
  assign gate_hi = hi_q;
  assign lo_rise = rise_q;

  // R5: outputs never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_q && hi_q));

  // R2: a high-side pulse is always preceded by the high-side dead interval
  a_r2_hi_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> $past(phase_q) == PH_HI_DEAD);

  // R7: a low enable turns both outputs off at the next edge
  a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!lo_q && !hi_q));

  // R8: the turn-on strobe lasts one cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

endmodule

// File: rtl/hbs_blank_timer.sv
module hbs_blank_timer #(
  parameter int BLANK_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic lo_rise,
  input  logic zc_raw,
  output logic blank_win,
  output logic zc_qual
);

  generate
    if (BLANK_CYC > 1) begin : g_cnt
      localparam int BW = $clog2(BLANK_CYC + 1);
      localparam logic [BW-1:0] LOAD = BW'(BLANK_CYC - 1);
      logic [BW-1:0] bcnt_q, bcnt_d;

      always_comb begin
        bcnt_d = bcnt_q;
        if (!run_en) begin
          bcnt_d = '0;
        end else if (lo_rise) begin
          bcnt_d = LOAD;
        end else if (bcnt_q != '0) begin
          bcnt_d = bcnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bcnt_q <= '0;
        end else begin
          bcnt_q <= bcnt_d;
        end
      end

      assign blank_win = lo_rise || (bcnt_q != '0);
    end else if (BLANK_CYC == 1) begin : g_one
      assign blank_win = lo_rise;
    end else begin : g_none
      assign blank_win = 1'b0;
    end
  endgenerate

  assign zc_qual = zc_raw && !blank_win;

  // R9: the window is open in the strobe cycle
  a_r9_blank_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rise |-> blank_win);

endmodule

// File: rtl/hbs_gate_seq.sv
module hbs_gate_seq
  import hbs_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter bit          FAST_DT    = 1'b0,
  parameter int          PER_W      = 16,
  parameter int          SLOW_DT_NS = 1800,
  parameter int          FAST_DT_NS = 1000,
  parameter int          BLANK_NS   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PER_W-1:0] period_in,
  input  logic             zc_raw,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             lo_rise,
  output logic             blank_win,
  output logic             zc_qual
);

  localparam int DT_NS     = FAST_DT ? FAST_DT_NS : SLOW_DT_NS;
  localparam int DT_CYC    = ns_to_cyc(longint'(DT_NS), longint'(CLK_HZ));
  localparam int BLANK_CYC = ns_to_cyc(longint'(BLANK_NS), longint'(CLK_HZ));

  logic             cycle_ld;
  logic [PER_W-1:0] on_len;

  hbs_period_latch #(.PER_W(PER_W), .DT_CYC(DT_CYC)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (cycle_ld),
    .period_in(period_in),
    .on_len   (on_len)
  );

  hbs_phase_fsm #(.PER_W(PER_W), .DT_CYC(DT_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .on_len  (on_len),
    .cycle_ld(cycle_ld),
    .gate_lo (gate_lo),
    .gate_hi (gate_hi),
    .lo_rise (lo_rise)
  );

  hbs_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .lo_rise  (lo_rise),
    .zc_raw   (zc_raw),
    .blank_win(blank_win),
    .zc_qual  (zc_qual)
  );

  // R1: idle outputs while disabled
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !$past(run_en)) |-> (!gate_lo && !gate_hi && !blank_win));

endmodule

// File: tb/tb_hbs_gate_seq.sv
module tb_hbs_gate_seq;

  localparam int PER_W = 16;
  localparam int DT    = 180;
  localparam int DT_F  = 100;
  localparam int BLANK = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic run_en_f = 1'b0;
  logic [PER_W-1:0] period_in = 16'd1000;
  logic zc_raw = 1'b0;
  logic gate_hi, gate_lo, lo_rise, blank_win, zc_qual;
  logic gate_hi_f, gate_lo_f, lo_rise_f, blank_win_f, zc_qual_f;

  int checks = 0;
  int failures = 0;
  int overlaps = 0;
  int hi_count = 0;

  always #5 clk = ~clk;

  hbs_gate_seq #(.FAST_DT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_in(period_in),
    .zc_raw(zc_raw), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .lo_rise(lo_rise), .blank_win(blank_win), .zc_qual(zc_qual)
  );

  hbs_gate_seq #(.FAST_DT(1'b1)) dut_f (
    .clk(clk), .rst_n(rst_n), .run_en(run_en_f), .period_in(period_in),
    .zc_raw(zc_raw), .gate_hi(gate_hi_f), .gate_lo(gate_lo_f),
    .lo_rise(lo_rise_f), .blank_win(blank_win_f), .zc_qual(zc_qual_f)
  );

  always @(negedge clk) begin
    if ((gate_hi && gate_lo) || (gate_hi_f && gate_lo_f)) overlaps++;
    if (gate_hi) hi_count++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_while(input bit on_hi, input bit lvl, output int n);
    n = 0;
    while (((on_hi ? gate_hi : gate_lo) == lvl) && n < 20000) begin
      step();
      n++;
    end
  endtask

  function automatic int on_time(input int p);
    int h;
    h = p / 2;
    if (h < DT + 1) h = DT + 1;
    return h - DT;
  endfunction

  task automatic restart(input int p);
    run_en = 1'b0;
    step();
    step();
    period_in = PER_W'(p);
    run_en = 1'b1;
  endtask

  task automatic t_reset();
    chk(!gate_hi && !gate_lo, "R1 gates in reset", {gate_hi, gate_lo}, 0);
    rst_n = 1'b1;
    step();
    step();
    chk(!gate_hi && !gate_lo, "R1 gates idle", {gate_hi, gate_lo}, 0);
    chk(!lo_rise && !blank_win, "R1 strobe/blank idle", {lo_rise, blank_win}, 0);
  endtask

  task automatic t_first_lo();
    int n;
    int h0;
    restart(1000);
    h0 = hi_count;
    count_while(1'b0, 1'b0, n);
    chk(n == DT + 1, "R2 first LO delay", n, DT + 1);
    chk(hi_count == h0, "R2 no HO before LO", hi_count - h0, 0);
    chk(lo_rise, "R8 strobe at LO rise", lo_rise, 1);
    step();
    chk(!lo_rise, "R8 strobe one cycle", lo_rise, 0);
  endtask

  task automatic t_cycle(input int p, input string req);
    int n;
    int on;
    on = on_time(p);
    restart(p);
    count_while(1'b0, 1'b0, n);
    count_while(1'b0, 1'b1, n);
    chk(n == on, {req, " LO on time"}, n, on);
    count_while(1'b1, 1'b0, n);
    chk(n == DT, {req, " dead before HO"}, n, DT);
    count_while(1'b1, 1'b1, n);
    chk(n == on, {req, " HO on time"}, n, on);
    count_while(1'b0, 1'b0, n);
    chk(n == DT, {req, " dead before LO"}, n, DT);
  endtask

  task automatic t_update();
    int n;
    restart(1000);
    count_while(1'b0, 1'b0, n);
    period_in = 16'd801;
    count_while(1'b0, 1'b1, n);
    chk(n == on_time(1000), "R6 current LO unchanged", n, on_time(1000));
    count_while(1'b1, 1'b0, n);
    count_while(1'b1, 1'b1, n);
    chk(n == on_time(1000), "R6 current HO unchanged", n, on_time(1000));
    count_while(1'b0, 1'b0, n);
    count_while(1'b0, 1'b1, n);
    chk(n == on_time(801), "R6 next LO uses new period", n, on_time(801));
  endtask

  task automatic t_disable();
    int n;
    int h0;
    restart(1000);
    count_while(1'b0, 1'b0, n);
    run_en = 1'b0;
    step();
    chk(!gate_lo && !gate_hi, "R7 outputs drop", {gate_hi, gate_lo}, 0);
    h0 = hi_count;
    repeat (600) step();
    chk(hi_count == h0 && !gate_lo, "R7 stay low while disabled", hi_count - h0, 0);
    run_en = 1'b1;
    count_while(1'b0, 1'b0, n);
    chk(n == DT + 1 && hi_count == h0, "R7 restart on LO", n, DT + 1);
  endtask

  task automatic t_fast();
    int n;
    run_en_f = 1'b1;
    n = 0;
    while (!gate_lo_f && n < 20000) begin
      step();
      n++;
    end
    chk(n == DT_F + 1, "R4 fast dead time", n, DT_F + 1);
    run_en_f = 1'b0;
    step();
  endtask

  task automatic t_blank();
    int n;
    zc_raw = 1'b1;
    restart(1000);
    count_while(1'b0, 1'b0, n);
    chk(blank_win && !zc_qual, "R9 masked at LO rise", zc_qual, 0);
    repeat (BLANK - 1) step();
    chk(blank_win, "R9 window still open", blank_win, 1);
    step();
    chk(!blank_win, "R9 window closes", blank_win, 0);
    chk(zc_qual, "R9 input passes after window", zc_qual, 1);
    zc_raw = 1'b0;
  endtask

  initial begin
    step();
    t_reset();
    t_first_lo();
    t_cycle(1000, "R3 P=1000");
    t_cycle(801, "R3 P=801");
    t_cycle(100, "R10 clamp");
    t_update();
    t_disable();
    t_fast();
    t_blank();
    chk(overlaps == 0, "R5 no overlap", overlaps, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule